// File: doc/BRIEF.md
# Byte-Select Bus Strobe Generator

This block turns one internal access request into the control strobes for a single 16-bit-wide external memory on one chip select. A request gives a byte address, a read/write flag and a size (byte or half-word). One clock edge later the block drives an active-low chip select, a write strobe shared by all writes, an output enable shared by all reads, and a pair of lane pins. It also drives the word address, which is the byte address shifted right by one, so bit 0 never drives an address line.

A static mode input sets the meaning of the lane pin pair. In byte-select mode (`lane_mode` = 0), the pair carries active-low enables for the lower (bits 7:0) and upper (bits 15:8) data byte. Such a device can read and write single bytes through its lane pins. In byte-write mode (`lane_mode` = 1), the device has no lane pins. The low pin then carries address bit 0 and the high pin, a second write strobe, is held inactive. A device in this mode cannot write a single byte, so such a write is refused and flagged.

Top module: `bus_strobe_gen`

## Requirements
- R1: After reset, and one cycle after any cycle with `req_valid` low, `cs_n`, `we_n`, `oe_n`, `lane_lo_n` and `lane_hi_n` are all 1 and `unsupported` is 0.
- R2: In byte-select mode, an accepted half-word access, or a byte access with address bit 0 = 0, drives `lane_lo_n` to 0. Any other accepted access leaves it at 1.
- R3: In byte-select mode, an accepted half-word access, or a byte access with address bit 0 = 1, drives `lane_hi_n` to 0. Any other accepted access leaves it at 1.
- R4: An accepted write drives `cs_n` = 0, `we_n` = 0 and `oe_n` = 1. An accepted read drives `cs_n` = 0, `oe_n` = 0 and `we_n` = 1. The outputs `we_n` and `oe_n` are never both 0.
- R5: For every valid request, `mem_addr` takes the request address bits [ADDR_W-1:1]. The value holds while no request is valid.
- R6: In byte-write mode, an accepted access drives `lane_lo_n` equal to address bit 0 and holds `lane_hi_n` at 1.
- R7: In byte-write mode, a byte-sized write (`req_half` = 0, `req_write` = 1) sets `unsupported` to 1 and leaves all five strobes at 1.
- R8: A half-word request with address bit 0 = 1 is misaligned. In either mode it sets `unsupported` to 1 and leaves all five strobes at 1.
- R9: All outputs are registered. They reflect the request sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lane_mode | input | 1 | 0 = byte-select, 1 = byte-write |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_half | input | 1 | 1 = half-word, 0 = byte |
| req_addr | input | ADDR_W | Byte address |
| cs_n | output | 1 | Chip select, active low |
| we_n | output | 1 | Shared write strobe, active low |
| oe_n | output | 1 | Shared output enable, active low |
| lane_lo_n | output | 1 | Low-byte enable, or address bit 0 in byte-write mode |
| lane_hi_n | output | 1 | High-byte enable, or inactive second write strobe |
| mem_addr | output | ADDR_W-1 | Word address to the device |
| unsupported | output | 1 | Request refused as misaligned or as an unwritable byte |

## Verification
A wrong lane decode shows as a byte enable asserted on the wrong half of the bus, one cycle after the request. A wrong mode decode shows as a refused write that still strobes `we_n` or `cs_n` on that same cycle. The outputs carry no state beyond one registered request. Every fault therefore appears at the ports on the first cycle after its triggering request, and the per-cycle comparison catches it there. Stale address bits are the exception, because the address holds across idle cycles. Such a fault shows only on the next valid request, so idle gaps are mixed between requests.

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lane_mode,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_half,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              cs_n,
  output logic              we_n,
  output logic              oe_n,
  output logic              lane_lo_n,
  output logic              lane_hi_n,
  output logic [ADDR_W-2:0] mem_addr,
  output logic              unsupported
);

  logic misaligned, byte_wr_refused, refuse, go;
  logic lo_on, hi_on;

  assign misaligned      = req_half & req_addr[0];
  assign byte_wr_refused = lane_mode & req_write & ~req_half;
  assign refuse          = misaligned | byte_wr_refused;
  assign go              = req_valid & ~refuse;
  assign lo_on           = req_half | ~req_addr[0];
  assign hi_on           = req_half |  req_addr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n        <= 1'b1;
      we_n        <= 1'b1;
      oe_n        <= 1'b1;
      lane_lo_n   <= 1'b1;
      lane_hi_n   <= 1'b1;
      mem_addr    <= '0;
      unsupported <= 1'b0;
    end else begin
      cs_n        <= ~go;
      we_n        <= ~(go & req_write);
      oe_n        <= ~(go & ~req_write);
      unsupported <= req_valid & refuse;
      if (lane_mode) begin
        lane_lo_n <= go ? req_addr[0] : 1'b1;
        lane_hi_n <= 1'b1;
      end else begin
        lane_lo_n <= ~(go & lo_on);
        lane_hi_n <= ~(go & hi_on);
      end
      if (req_valid) mem_addr <= req_addr[ADDR_W-1:1];
    end
  end

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (cs_n && we_n && oe_n && lane_lo_n && lane_hi_n && !unsupported));

  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !oe_n));

  assert_strobe_needs_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || !oe_n) |-> !cs_n);

  assert_lane_present_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!lane_mode && go) |=> (!lane_lo_n || !lane_hi_n));

  assert_hi_idle_bytewrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lane_mode |=> lane_hi_n);

  assert_refused_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    unsupported |-> (cs_n && we_n && oe_n && lane_lo_n && lane_hi_n));

  assert_misaligned_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_half && req_addr[0]) |=> unsupported);

  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(mem_addr));

endmodule

// File: tb/tb_bus_strobe_gen.sv
module tb_bus_strobe_gen;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lane_mode = 1'b0, req_valid = 1'b0, req_write = 1'b0, req_half = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic cs_n, we_n, oe_n, lane_lo_n, lane_hi_n, unsupported;
  logic [ADDR_W-2:0] mem_addr;

  int compared = 0, mismatched = 0;
  bit e_cs = 1, e_we = 1, e_oe = 1, e_lo = 1, e_hi = 1, e_un = 0;
  bit [ADDR_W-2:0] e_addr = '0;
  string tag_lane = "R1", tag_un = "R1";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_strobe_gen #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .lane_mode(lane_mode), .req_valid(req_valid),
    .req_write(req_write), .req_half(req_half), .req_addr(req_addr),
    .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n), .lane_lo_n(lane_lo_n),
    .lane_hi_n(lane_hi_n), .mem_addr(mem_addr), .unsupported(unsupported));

  task automatic chk(string req, string what, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R4", "cs_n", cs_n, e_cs);
    chk("R4", "we_n", we_n, e_we);
    chk("R4", "oe_n", oe_n, e_oe);
    chk(tag_lane, "lane_lo_n", lane_lo_n, e_lo);
    chk(tag_lane == "R2" ? "R3" : tag_lane, "lane_hi_n", lane_hi_n, e_hi);
    chk("R5", "mem_addr", mem_addr, e_addr);
    chk(tag_un, "unsupported", unsupported, e_un);
  endtask

  // R9: expectation computed from the inputs that the next rising edge samples
  task automatic predict();
    bit bad;
    if (!rst_n || !req_valid) begin
      e_cs = 1; e_we = 1; e_oe = 1; e_lo = 1; e_hi = 1; e_un = 0;
      tag_lane = "R1"; tag_un = "R1";
      return;
    end
    e_addr = req_addr >> 1;
    bad = 0; tag_un = "R4";
    if (req_half && req_addr[0]) begin bad = 1; tag_un = "R8"; end
    else if (lane_mode && req_write && !req_half) begin bad = 1; tag_un = "R7"; end
    e_un = bad;
    if (bad) begin
      e_cs = 1; e_we = 1; e_oe = 1; e_lo = 1; e_hi = 1; tag_lane = tag_un;
    end else begin
      e_cs = 0; e_we = !req_write; e_oe = req_write;
      if (lane_mode) begin
        tag_lane = "R6"; e_lo = req_addr[0]; e_hi = 1;
      end else begin
        tag_lane = "R2";
        e_lo = !(req_half || !req_addr[0]);
        e_hi = !(req_half || req_addr[0]);
      end
    end
  endtask

  task automatic step(bit m, bit v, bit w, bit h, logic [ADDR_W-1:0] a);
    @(negedge clk);
    check_all();
    lane_mode = m; req_valid = v; req_write = w; req_half = h; req_addr = a;
    predict();
  endtask

  initial begin
    repeat (3) begin @(negedge clk); check_all(); end
    rst_n = 1'b1;
    predict();
    // byte-select mode: lanes per size and address bit 0
    step(0, 1, 0, 0, 24'h000100);
    step(0, 1, 0, 0, 24'h000101);
    step(0, 1, 1, 1, 24'h00ABC2);
    step(0, 1, 1, 0, 24'h000003);
    step(0, 0, 1, 1, 24'hFFFFFF);
    step(0, 1, 0, 1, 24'h000005);
    step(0, 1, 1, 1, 24'hFFFFFE);
    // byte-write mode
    step(1, 1, 1, 0, 24'h000010);
    step(1, 1, 0, 0, 24'h000011);
    step(1, 1, 0, 0, 24'h000012);
    step(1, 1, 1, 1, 24'h000012);
    step(1, 1, 1, 1, 24'h000013);
    step(1, 0, 0, 0, 24'h000000);
    for (int i = 0; i < 2000; i++) begin
      int r;
      r = $urandom;
      step(r[0], r[3:1] != 0, r[4], r[5], ADDR_W'($urandom));
    end
    step(0, 0, 0, 0, 24'h0);
    @(negedge clk); check_all();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL R9 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule